// File: doc/BRIEF.md
# Way-predicting two-way cache lookup

This block is the hit path of a two-way set-associative cache that reads one way first. Every set holds a single prediction bit naming the way to try first. When a request has been accepted, the block reads the line of the predicted way and compares its tag in the same cycle. The output word is selected from that way before the tag result is known. If the predicted way holds the line, the word is returned one clock edge after acceptance. If it does not, the other way of the set is probed in the next cycle. A hit found there is returned one edge later and marked as slow. If neither way holds the line, the block reports a miss.

Lines arrive through a plain fill port. A fill writes the whole line into the way of its set that was not used most recently, and it points the set's prediction at that way. After every hit the recency bit of the set names the way that hit. After a hit in the second probe, the prediction of the set is moved to that way. A caller issues requests with a valid and an address and holds off while the ready output is low. The ready output is low only in the cycle in which the first probe misses.

Top module: `wp_cache_lookup`

## Requirements
- R1: After an active-low asynchronous reset, ready is high and no response is valid. Every line is invalid, every prediction names way 0 and every recency bit names way 1, so the first fill of any set goes to way 0.
- R2: When the predicted way holds the line, the response arrives one clock edge after the accepting edge, with hit=1, miss=0 and slow=0.
- R3: On a hit, the response data is word `addr[3:2]` of the 16-byte line, where word w sits at bits [32w+31:32w] of the fill line.
- R4: When only the non-predicted way holds the line, the response arrives two clock edges after the accepting edge, with hit=1, slow=1 and miss=0.
- R5: When neither way holds the line, the response arrives two clock edges after the accepting edge, with miss=1, hit=0, slow=0 and data 0.
- R6: After a slow hit, the prediction of that set names the way that hit, so the next access to that line is a fast hit.
- R7: A fill writes the way that is not most recently used in its set and sets the prediction of that set to the same way. A hit marks the hitting way as most recently used.
- R8: Ready is low exactly in the cycle after an accepting edge whose predicted probe misses. Fast hits can therefore be accepted on consecutive cycles and answered on consecutive cycles.
- R9: hit and miss are never high together. While the response is valid, exactly one of them is high. While it is not valid, hit, miss and slow are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | 32 | Byte address of the lookup |
| req_ready_o | output | 1 | Request accepted on this edge when high |
| fill_valid_i | input | 1 | Write a line into the cache |
| fill_addr_i | input | 32 | Address of the line being filled |
| fill_line_i | input | 128 | Line data; word w at bits [32w+31:32w] |
| resp_valid_o | output | 1 | Response valid |
| resp_data_o | output | 32 | Selected word on a hit, zero otherwise |
| resp_hit_o | output | 1 | The line was found |
| resp_miss_o | output | 1 | Neither way holds the line |
| resp_slow_o | output | 1 | Hit found in the second probe |

## Verification
A fast hit appears one edge after the accepting edge. A slow hit or a miss appears two edges after it, and ready drops in the single cycle in between. The bench drives inputs and samples outputs on falling edges. After every accepting edge it counts rising edges until the response shows, then compares that count with the latency that R2, R4 or R5 calls for, along with the flags and the data word. It reads ready in the cycle right after acceptance to check R8, and it uses a back-to-back pair of fast hits to confirm that the responses come on adjacent cycles.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } probe_st_e;
endpackage

// File: rtl/wp_way_store.sv
module wp_way_store #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              match_o,
  output logic [LINE_W-1:0] line_o
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // arrays carry no reset; valid bit guards them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_line_i;
    end
  end

  assign match_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign line_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int unsigned SETS = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             pred_o,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             fill_en_i,
  output logic             victim_o,
  input  logic             hit_en_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             hit_way_i,
  input  logic             hit_repredict_i
);
  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] mru_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic fill_here, hit_here;
    assign fill_here = fill_en_i && (fill_idx_i == IDX_W'(s));
    assign hit_here  = hit_en_i  && (hit_idx_i  == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pred_q[s] <= 1'b0;
        mru_q[s]  <= 1'b1;
      end else if (fill_here) begin
        // fill wins over a same-cycle hit update
        pred_q[s] <= ~mru_q[s];
        mru_q[s]  <= ~mru_q[s];
      end else if (hit_here) begin
        mru_q[s] <= hit_way_i;
        if (hit_repredict_i) pred_q[s] <= hit_way_i;
      end
    end
  end

  assign pred_o   = pred_q[rd_idx_i];
  assign victim_o = ~mru_q[fill_idx_i];
endmodule

// File: rtl/wp_probe_ctrl.sv
module wp_probe_ctrl
  import wp_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 64,
  parameter int unsigned LINE_B = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned OFF_W  = $clog2(LINE_B),
  localparam int unsigned BOFF_W = $clog2(WORD_W/8),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LINE_W = LINE_B * 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  input  logic [ADDR_W-1:0]                req_addr_i,
  output logic                             ready_o,
  input  logic                             pred_i,
  input  logic [NUM_WAYS-1:0]              hit_i,
  input  logic [NUM_WAYS-1:0][LINE_W-1:0]  lines_i,
  output logic [IDX_W-1:0]                 lk_idx_o,
  output logic [TAG_W-1:0]                 lk_tag_o,
  output logic                             upd_en_o,
  output logic                             upd_way_o,
  output logic                             upd_repredict_o,
  output logic                             resp_valid_o,
  output logic [WORD_W-1:0]                resp_data_o,
  output logic                             resp_hit_o,
  output logic                             resp_miss_o,
  output logic                             resp_slow_o
);
  probe_st_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              alt_q;
  logic              probe_way, probe_hit, accept;
  logic [LINE_W-1:0] sel_line;
  logic [WORD_W-1:0] sel_word;
  logic [BOFF_W-1:0] unused_byte_off;

  assign lk_idx_o        = addr_q[OFF_W +: IDX_W];
  assign lk_tag_o        = addr_q[ADDR_W-1 -: TAG_W];
  assign unused_byte_off = addr_q[BOFF_W-1:0];

  // mux steered by prediction before the tag result settles
  assign probe_way = (state_q == ST_SECOND) ? alt_q : pred_i;
  assign sel_line  = lines_i[probe_way];
  assign sel_word  = sel_line[addr_q[OFF_W-1:BOFF_W]*WORD_W +: WORD_W];
  assign probe_hit = (state_q != ST_IDLE) && hit_i[probe_way];

  assign ready_o = !((state_q == ST_FIRST) && !probe_hit);
  assign accept  = req_valid_i && ready_o;

  assign upd_en_o        = probe_hit;
  assign upd_way_o       = probe_way;
  assign upd_repredict_o = (state_q == ST_SECOND);

  always_comb begin
    state_d = accept ? ST_FIRST : ST_IDLE;
    if (state_q == ST_FIRST && !probe_hit) state_d = ST_SECOND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      alt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= req_addr_i;
      if (state_q == ST_FIRST) alt_q <= ~pred_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_miss_o  <= 1'b0;
      resp_slow_o  <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= probe_hit || (state_q == ST_SECOND);
      resp_hit_o   <= probe_hit;
      resp_miss_o  <= (state_q == ST_SECOND) && !probe_hit;
      resp_slow_o  <= (state_q == ST_SECOND) && probe_hit;
      resp_data_o  <= probe_hit ? sel_word : '0;
    end
  end
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wp_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 64,
  parameter int unsigned LINE_B = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned OFF_W  = $clog2(LINE_B),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LINE_W = LINE_B * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              resp_valid_o,
  output logic [WORD_W-1:0] resp_data_o,
  output logic              resp_hit_o,
  output logic              resp_miss_o,
  output logic              resp_slow_o
);
  logic [IDX_W-1:0]                lk_idx, fill_idx;
  logic [TAG_W-1:0]                lk_tag, fill_tag;
  logic [NUM_WAYS-1:0]             way_hit;
  logic [NUM_WAYS-1:0][LINE_W-1:0] way_line;
  logic                            pred, victim;
  logic                            upd_en, upd_way, upd_repredict;
  logic [OFF_W-1:0]                unused_fill_off;

  assign fill_idx        = fill_addr_i[OFF_W +: IDX_W];
  assign fill_tag        = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_fill_off = fill_addr_i[OFF_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic             wr_en;
    logic             match;
    logic [LINE_W-1:0] line;
    assign wr_en = fill_valid_i && (victim == 1'(w));

    wp_way_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (fill_idx),
      .wr_tag_i  (fill_tag),
      .wr_line_i (fill_line_i),
      .rd_idx_i  (lk_idx),
      .rd_tag_i  (lk_tag),
      .match_o   (match),
      .line_o    (line)
    );
    assign way_hit[w]  = match;
    assign way_line[w] = line;
  end

  wp_pred_table #(.SETS(SETS)) u_pred (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_idx_i        (lk_idx),
    .pred_o          (pred),
    .fill_idx_i      (fill_idx),
    .fill_en_i       (fill_valid_i),
    .victim_o        (victim),
    .hit_en_i        (upd_en),
    .hit_idx_i       (lk_idx),
    .hit_way_i       (upd_way),
    .hit_repredict_i (upd_repredict)
  );

  wp_probe_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .LINE_B(LINE_B), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_addr_i      (req_addr_i),
    .ready_o         (req_ready_o),
    .pred_i          (pred),
    .hit_i           (way_hit),
    .lines_i         (way_line),
    .lk_idx_o        (lk_idx),
    .lk_tag_o        (lk_tag),
    .upd_en_o        (upd_en),
    .upd_way_o       (upd_way),
    .upd_repredict_o (upd_repredict),
    .resp_valid_o    (resp_valid_o),
    .resp_data_o     (resp_data_o),
    .resp_hit_o      (resp_hit_o),
    .resp_miss_o     (resp_miss_o),
    .resp_slow_o     (resp_slow_o)
  );
endmodule

// File: rtl/wp_cache_lookup_chk.sv
module wp_cache_lookup_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 128,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic              fill_valid_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic [LINE_W-1:0] fill_line_i,
  input logic              resp_valid_o,
  input logic [WORD_W-1:0] resp_data_o,
  input logic              resp_hit_o,
  input logic              resp_miss_o,
  input logic              resp_slow_o
);
  logic acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= 1'b0;
    else         acc_q <= req_valid_i && req_ready_o;
  end

  p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_hit_o ^ resp_miss_o));

  p_flag_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(resp_hit_o || resp_miss_o || resp_slow_o));

  p_slow_is_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_slow_o |-> resp_hit_o);

  p_fast_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && req_ready_o) |=> (resp_valid_o && resp_hit_o && !resp_slow_o));

  p_stall_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && !req_ready_o) |=> (!resp_valid_o && req_ready_o));

  p_stall_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && !req_ready_o) |-> ##2 resp_valid_o);

  p_miss_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_miss_o |-> (resp_data_o == '0));
endmodule

bind wp_cache_lookup wp_cache_lookup_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/wp_cache_lookup_tb.sv
module wp_cache_lookup_tb;
  localparam int K_FAST = 0, K_SLOW = 1, K_MISS = 2, K_NA = 3;
  localparam logic [1:0] OP_ACC = 2'd0, OP_FILL = 2'd1;
  localparam int N_VEC = 14;

  // {op, addr, expected kind}; set 5 holds tags A/B/C
  localparam logic [35:0] VEC [N_VEC] = '{
    {OP_ACC,  32'h0001_2054, 2'd2},  // A cold: R5, R1
    {OP_FILL, 32'h0001_2050, 2'd3},  // A -> way0 (R7)
    {OP_ACC,  32'h0001_2054, 2'd0},  // fast
    {OP_FILL, 32'h0003_4050, 2'd3},  // B -> way1, pred 1 (R7)
    {OP_ACC,  32'h0003_405C, 2'd0},  // fast
    {OP_ACC,  32'h0001_2058, 2'd1},  // A slow, pred -> 0
    {OP_ACC,  32'h0001_2050, 2'd0},  // fast after slow (R6)
    {OP_ACC,  32'h0003_4050, 2'd1},  // B slow, pred -> 1
    {OP_FILL, 32'h0005_6050, 2'd3},  // C replaces A in way0 (R7)
    {OP_ACC,  32'h0001_2050, 2'd2},  // A gone
    {OP_ACC,  32'h0005_6054, 2'd0},  // C fast
    {OP_ACC,  32'h0003_4058, 2'd1},  // B slow
    {OP_ACC,  32'h0003_4054, 2'd0},  // B fast (R6)
    {OP_ACC,  32'h0005_6090, 2'd2}   // other set empty
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [31:0]  req_addr_i = '0;
  logic         req_ready_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [127:0] fill_line_i = '0;
  logic         resp_valid_o;
  logic [31:0]  resp_data_o;
  logic         resp_hit_o, resp_miss_o, resp_slow_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wp_cache_lookup u_dut (.*);

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of({a[31:4], 2'(w), 2'b00});
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic do_fill(input logic [31:0] a);
    fill_valid_i = 1'b1;
    fill_addr_i  = a;
    fill_line_i  = line_of(a);
    @(posedge clk_i);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic do_access(input logic [31:0] a, input int kind);
    int lat;
    string tag;
    tag = (kind == K_FAST) ? "R2/R6/R7" : (kind == K_SLOW) ? "R4/R7" : "R5";
    req_valid_i = 1'b1;
    req_addr_i  = a;
    chk(req_ready_o === 1'b1, "R8 idle ready", 64'(req_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o === (kind == K_FAST), "R8 ready after accept", 64'(req_ready_o), 64'(kind == K_FAST));
    lat = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      if (resp_valid_o) break;
    end
    chk(lat == ((kind == K_FAST) ? 1 : 2), {tag, " latency"}, 64'(lat), (kind == K_FAST) ? 1 : 2);
    chk(resp_hit_o === (kind != K_MISS), {tag, " hit"}, 64'(resp_hit_o), 64'(kind != K_MISS));
    chk(resp_miss_o === (kind == K_MISS), {tag, " miss"}, 64'(resp_miss_o), 64'(kind == K_MISS));
    chk(resp_slow_o === (kind == K_SLOW), {tag, " slow"}, 64'(resp_slow_o), 64'(kind == K_SLOW));
    chk(resp_data_o === ((kind == K_MISS) ? 32'h0 : word_of(a)), "R3/R5 data",
        64'(resp_data_o), 64'((kind == K_MISS) ? 32'h0 : word_of(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o === 1'b1, "R1 ready in reset", 64'(req_ready_o), 1);
    chk(resp_valid_o === 1'b0, "R1 no response in reset", 64'(resp_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][35:34] == OP_FILL) do_fill(VEC[i][33:2]);
      else                          do_access(VEC[i][33:2], int'(VEC[i][1:0]));
    end

    // R8: two fast hits back to back in set 12
    do_fill(32'h0007_80C0);
    req_valid_i = 1'b1;
    req_addr_i  = 32'h0007_80C4;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req_ready_o === 1'b1, "R8 ready during fast hit", 64'(req_ready_o), 1);
    req_addr_i = 32'h0007_80C8;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(resp_valid_o && resp_hit_o && resp_data_o == word_of(32'h0007_80C4),
        "R8 first back-to-back", 64'(resp_data_o), 64'(word_of(32'h0007_80C4)));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(resp_valid_o && resp_hit_o && !resp_slow_o && resp_data_o == word_of(32'h0007_80C8),
        "R8 second back-to-back", 64'(resp_data_o), 64'(word_of(32'h0007_80C8)));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(resp_valid_o === 1'b0, "R9 quiet when idle", 64'(resp_valid_o), 0);

    // R1: reset mid-run clears lines and predictions
    rst_ni = 1'b0;
    #1;
    chk(req_ready_o === 1'b1 && resp_valid_o === 1'b0, "R1 async reset",
        64'({req_ready_o, resp_valid_o}), 64'h2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_access(32'h0003_4054, K_MISS);
    do_fill(32'h0003_4050);          // R1/R7: way0, pred 0
    do_access(32'h0003_4058, K_FAST);
    do_fill(32'h0001_2050);          // R7: way1, pred 1
    do_access(32'h0003_4050, K_SLOW);
    do_access(32'h0001_205C, K_SLOW);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule